// File: doc/BRIEF.md
# Reset Source Aggregator with Cause Register

This block gathers eight independent reset requests into one active-high system reset and keeps a 16-bit cause register for software. The eight requests are power-on, external pin, reset instruction, watchdog timeout, brown-out, trap conflict, illegal opcode and uninitialized working-register use. The analog detectors and the watchdog counter sit outside the block and arrive here as digital levels.

The external pin request is debounced by a glitch filter. The filter accepts the request only after it has stayed high for a run of consecutive clocks. The system reset is released in step with the clock, a fixed number of clocks after the last active source goes away. Software reads the cause flags through a plain read port and rewrites them through a write strobe. Writing a flag only changes the record and never starts a reset. Only the power-on request clears the record.

Top module: `rstSourceAgg`

## Requirements
- R1: If any of the eight sources is active when a rising clock edge samples it, `sysRst` is high after that edge. The pin source counts only once it has passed the filter. Several sources may be active together.
- R2: The pin request counts as active only after it has been sampled high on `FILT_LEN` consecutive rising edges (default 4). A shorter pulse neither raises `sysRst` nor sets a flag. A sample of zero restarts the count.
- R3: `sysRst` falls exactly `HOLD_LEN` rising edges (default 16) after the last edge that sampled an active source. While `porReq` is high, `sysRst` is high at once, without waiting for a clock.
- R4: While `porReq` is high, the cause register reads 0x0003: the power-on flag (bit 0) and the brown-out flag (bit 1) are set and every other bit is clear. The register holds 0x0003 after `porReq` is released until some other event changes it.
- R5: Each non-power-on source sets its own flag on every edge at which it is active: brown-out bit 1, watchdog bit 4, instruction bit 6, pin bit 7, uninitialized register bit 9, illegal opcode bit 14, trap conflict bit 15.
- R6: A new reset cause other than power-on sets its flag without clearing flags already set, so causes accumulate.
- R7: With `regWrEn` high, the register loads `regWrData` on the next edge, with the undefined bits forced to zero. The defined-bit mask is 0xC2D3, so the undefined bits always read 0.
- R8: A register write never asserts `sysRst`.
- R9: If a write and a cause capture fall on the same edge, the cause flag ends up set whatever the written value is.
- R10: Once the reset it caused is released, the cause register is unchanged. Only `porReq` clears flags in hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porReq | input | 1 | Power-on request, asynchronous assert; also resets the block |
| pinReq | input | 1 | Raw external pin reset request, filtered inside |
| instrReq | input | 1 | Reset-instruction request |
| wdtReq | input | 1 | Watchdog timeout request |
| borReq | input | 1 | Brown-out request |
| trapReq | input | 1 | Trap conflict request |
| illegalReq | input | 1 | Illegal opcode request |
| uninitReq | input | 1 | Uninitialized working-register request |
| regWrEn | input | 1 | Cause register write strobe |
| regWrData | input | 16 | Cause register write data |
| regRdData | output | 16 | Cause register read data |
| sysRst | output | 1 | Aggregated system reset, active high |

## Verification
The assertions check the cycle-level rules on every clock. Any active source raises the reset on the next edge. A zero pin sample clears the filter output. The reset only falls when no source was active. A cause wins over a same-edge write. Flags never drop without a write. A quiet cycle never starts a reset. The bench scenarios show what a single-cycle property cannot: the exact length of the release stretch, the filter rejecting a three-clock pulse while accepting a four-clock one, the bit position of each cause, the flags accumulating across several resets, and a power-on arriving mid-run and wiping the record back to 0x0003.

// File: rtl/rstAggPkg.sv
package rstAggPkg;

  localparam int FLAG_W  = 16;
  localparam int NUM_SRC = 8;

  // Source indices on the request vector
  localparam int SRC_POR     = 0;
  localparam int SRC_BOR     = 1;
  localparam int SRC_WDT     = 2;
  localparam int SRC_INSTR   = 3;
  localparam int SRC_PIN     = 4;
  localparam int SRC_UNINIT  = 5;
  localparam int SRC_ILLEGAL = 6;
  localparam int SRC_TRAP    = 7;

  // Flag bit position for each source index
  function automatic int srcFlagPos(input int idx);
    case (idx)
      SRC_POR:     return 0;
      SRC_BOR:     return 1;
      SRC_WDT:     return 4;
      SRC_INSTR:   return 6;
      SRC_PIN:     return 7;
      SRC_UNINIT:  return 9;
      SRC_ILLEGAL: return 14;
      default:     return 15;
    endcase
  endfunction

  function automatic logic [FLAG_W-1:0] buildMask();
    logic [FLAG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SRC; i++) m[srcFlagPos(i)] = 1'b1;
    return m;
  endfunction

  localparam logic [FLAG_W-1:0] FLAG_MASK = buildMask();
  localparam logic [FLAG_W-1:0] POR_VALUE =
    (FLAG_W'(1) << srcFlagPos(SRC_POR)) | (FLAG_W'(1) << srcFlagPos(SRC_BOR));

  // Strobes from control to the flag datapath
  typedef struct packed {
    logic [FLAG_W-1:0] causeSet;
    logic              anyCause;
  } rstStrobe_t;

endpackage

// File: rtl/rstGlitchFilter.sv
module rstGlitchFilter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic porReq,
  input  logic rawIn,
  output logic valid
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_LEN);

  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)                runCnt <= '0;
    else if (!rawIn)           runCnt <= '0;
    else if (runCnt != CNT_MAX) runCnt <= runCnt + CNT_W'(1);
  end

  assign valid = (runCnt == CNT_MAX);

  // R2: a zero sample always drops the filtered output
  p_drop_clears_r2: assert property (@(posedge clk) disable iff (porReq)
    !rawIn |=> !valid);

  // R2: output can only rise while the raw input is held
  p_rise_needs_input_r2: assert property (@(posedge clk) disable iff (porReq)
    $rose(valid) |-> $past(rawIn));

endmodule

// File: rtl/rstAggCtrl.sv
module rstAggCtrl
  import rstAggPkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD_LEN = 16
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       pinReq,
  input  logic       instrReq,
  input  logic       wdtReq,
  input  logic       borReq,
  input  logic       trapReq,
  input  logic       illegalReq,
  input  logic       uninitReq,
  output rstStrobe_t ctrlStrobe,
  output logic       sysRst
);
  localparam int HOLD_W = $clog2(HOLD_LEN + 1);
  localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLD_LEN);

  logic               pinValid;
  logic [NUM_SRC-1:0] srcVec;
  logic [FLAG_W-1:0]  causeVec;
  logic               anyReq;
  logic [HOLD_W-1:0]  holdCnt;

  rstGlitchFilter #(.FILT_LEN(FILT_LEN)) uPinFilt (
    .clk    (clk),
    .porReq (porReq),
    .rawIn  (pinReq),
    .valid  (pinValid)
  );

  always_comb begin
    srcVec              = '0;
    srcVec[SRC_POR]     = porReq;
    srcVec[SRC_BOR]     = borReq;
    srcVec[SRC_WDT]     = wdtReq;
    srcVec[SRC_INSTR]   = instrReq;
    srcVec[SRC_PIN]     = pinValid;
    srcVec[SRC_UNINIT]  = uninitReq;
    srcVec[SRC_ILLEGAL] = illegalReq;
    srcVec[SRC_TRAP]    = trapReq;
  end

  // Scatter source levels onto their flag positions
  always_comb begin
    causeVec = '0;
    for (int i = 0; i < NUM_SRC; i++) causeVec[srcFlagPos(i)] = srcVec[i];
  end

  assign anyReq = |srcVec;

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)             holdCnt <= HOLD_MAX;
    else if (anyReq)        holdCnt <= HOLD_MAX;
    else if (holdCnt != '0) holdCnt <= holdCnt - HOLD_W'(1);
  end

  assign sysRst              = (holdCnt != '0);
  assign ctrlStrobe.causeSet = causeVec;
  assign ctrlStrobe.anyCause = anyReq;

  // R1: any active source raises reset on the next edge
  p_any_raises_rst_r1: assert property (@(posedge clk) disable iff (porReq)
    anyReq |=> sysRst);

  // R3: reset only releases after a quiet edge
  p_release_quiet_r3: assert property (@(posedge clk) disable iff (porReq)
    $fell(sysRst) |-> !$past(anyReq));

endmodule

// File: rtl/rstAggFlags.sv
module rstAggFlags
  import rstAggPkg::*;
(
  input  logic              clk,
  input  logic              porReq,
  input  rstStrobe_t        ctrlStrobe,
  input  logic              wrEn,
  input  logic [FLAG_W-1:0] wrData,
  output logic [FLAG_W-1:0] rdData
);
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] nextFlags;

  // Write first, then hardware causes OR on top so they win
  always_comb begin
    nextFlags = flags;
    if (wrEn) nextFlags = wrData & FLAG_MASK;
    nextFlags = nextFlags | (ctrlStrobe.causeSet & FLAG_MASK);
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) flags <= POR_VALUE;
    else        flags <= nextFlags;
  end

  assign rdData = flags;

  // R9: captured cause bits are set after the edge
  p_cause_wins_r9: assert property (@(posedge clk) disable iff (porReq)
    ctrlStrobe.anyCause |=> ((flags & $past(ctrlStrobe.causeSet)) == $past(ctrlStrobe.causeSet)));

  // R7: a write with no cause loads the masked data
  p_write_loads_r7: assert property (@(posedge clk) disable iff (porReq)
    (wrEn && !ctrlStrobe.anyCause) |=> (flags == ($past(wrData) & FLAG_MASK)));

  // R6 / R10: without a write, no flag is ever cleared
  p_flags_keep_r6: assert property (@(posedge clk) disable iff (porReq)
    !wrEn |=> ((flags & $past(flags)) == $past(flags)));

endmodule

// File: rtl/rstSourceAgg.sv
module rstSourceAgg
  import rstAggPkg::*;
#(
  parameter int FILT_LEN = 4,
  parameter int HOLD_LEN = 16
) (
  input  logic        clk,
  input  logic        porReq,
  input  logic        pinReq,
  input  logic        instrReq,
  input  logic        wdtReq,
  input  logic        borReq,
  input  logic        trapReq,
  input  logic        illegalReq,
  input  logic        uninitReq,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        sysRst
);
  rstStrobe_t ctrlStrobe;

  rstAggCtrl #(.FILT_LEN(FILT_LEN), .HOLD_LEN(HOLD_LEN)) uCtrl (
    .clk        (clk),
    .porReq     (porReq),
    .pinReq     (pinReq),
    .instrReq   (instrReq),
    .wdtReq     (wdtReq),
    .borReq     (borReq),
    .trapReq    (trapReq),
    .illegalReq (illegalReq),
    .uninitReq  (uninitReq),
    .ctrlStrobe (ctrlStrobe),
    .sysRst     (sysRst)
  );

  rstAggFlags uFlags (
    .clk        (clk),
    .porReq     (porReq),
    .ctrlStrobe (ctrlStrobe),
    .wrEn       (regWrEn),
    .wrData     (regWrData),
    .rdData     (regRdData)
  );

  // R8: with no cause and reset released, nothing (a write included) raises reset
  p_write_no_rst_r8: assert property (@(posedge clk) disable iff (porReq)
    (!ctrlStrobe.anyCause && !sysRst) |=> !sysRst);

endmodule

// File: tb/sim_rstSourceAgg.sv
module sim_rstSourceAgg;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        porReq, pinReq, instrReq, wdtReq, borReq, trapReq, illegalReq, uninitReq;
  logic        regWrEn;
  logic [15:0] regWrData;
  logic [15:0] regRdData;
  logic        sysRst;

  int testsRun = 0;
  int testsFailed = 0;
  logic [15:0] expFlags;

  typedef struct {
    string       tag;
    logic        expSys;
    logic [15:0] expFl;
  } expItem_t;

  expItem_t scq[$];

  rstSourceAgg u0 (
    .clk(clk), .porReq(porReq), .pinReq(pinReq), .instrReq(instrReq),
    .wdtReq(wdtReq), .borReq(borReq), .trapReq(trapReq),
    .illegalReq(illegalReq), .uninitReq(uninitReq),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .sysRst(sysRst)
  );

  always #(CLK_P/2) clk = ~clk;

  // Monitor: compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_P/4);
    if (scq.size() > 0) begin
      expItem_t it;
      it = scq.pop_front();
      testsRun++;
      if (sysRst !== it.expSys || regRdData !== it.expFl) begin
        testsFailed++;
        $display("FAIL %s: sysRst=%0b flags=%h expected sysRst=%0b flags=%h",
                 it.tag, sysRst, regRdData, it.expSys, it.expFl);
      end
    end
  end

  // Driver: push expectation for the coming edge, then advance one cycle
  task automatic tick(input string tag, input logic sys, input logic [15:0] fl);
    expItem_t it;
    it.tag = tag; it.expSys = sys; it.expFl = fl;
    scq.push_back(it);
    @(negedge clk);
  endtask

  task automatic relax(input string tag, input int n);
    for (int i = 1; i <= n; i++) tick(tag, (i < n), expFlags);
  endtask

  task automatic setSrc(input int which, input logic v);
    case (which)
      1: borReq = v;
      4: wdtReq = v;
      6: instrReq = v;
      9: uninitReq = v;
      14: illegalReq = v;
      default: trapReq = v;
    endcase
  endtask

  task automatic pulseSrc(input int bitPos, input string tag);
    setSrc(bitPos, 1'b1);
    expFlags = expFlags | (16'h1 << bitPos);
    tick(tag, 1'b1, expFlags);
    setSrc(bitPos, 1'b0);
    relax("R3 R10 release keeps flags", 16);
  endtask

  task automatic swWrite(input logic [15:0] d, input string tag);
    regWrEn = 1'b1; regWrData = d;
    expFlags = d & 16'hC2D3;
    tick(tag, 1'b0, expFlags);
    regWrEn = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    porReq = 1'b1; pinReq = 1'b0; instrReq = 1'b0; wdtReq = 1'b0; borReq = 1'b0;
    trapReq = 1'b0; illegalReq = 1'b0; uninitReq = 1'b0;
    regWrEn = 1'b0; regWrData = 16'h0;
    expFlags = 16'h0003;
    @(negedge clk);
    tick("R4 power-on state", 1'b1, 16'h0003);
    tick("R4 power-on held", 1'b1, 16'h0003);
    porReq = 1'b0;
    relax("R3 R4 power-on release", 16);

    // R7 / R8: software writes
    swWrite(16'hFFFF, "R7 R8 write all ones masked");
    tick("R8 no reset after write", 1'b0, expFlags);
    tick("R8 still released", 1'b0, expFlags);
    swWrite(16'h0000, "R7 R8 write clears");

    // R1 R5 R6: each source, accumulating
    pulseSrc(4,  "R1 R5 watchdog bit4");
    pulseSrc(6,  "R5 R6 instruction bit6");
    pulseSrc(15, "R5 R6 trap bit15");
    pulseSrc(14, "R5 R6 illegal bit14");
    pulseSrc(9,  "R5 R6 uninit bit9");
    pulseSrc(1,  "R5 R6 brown-out bit1");

    // R1: two sources together
    swWrite(16'h0000, "R7 clear before multi");
    trapReq = 1'b1; illegalReq = 1'b1;
    expFlags = 16'hC000;
    tick("R1 two sources together", 1'b1, expFlags);
    trapReq = 1'b0; illegalReq = 1'b0;
    relax("R3 R10 release after multi", 16);

    // R2: short pin pulse rejected
    swWrite(16'h0000, "R7 clear before pin");
    pinReq = 1'b1;
    for (int i = 0; i < 3; i++) tick("R2 short pin pulse ignored", 1'b0, 16'h0);
    pinReq = 1'b0;
    tick("R2 short pulse no reset", 1'b0, 16'h0);
    tick("R2 short pulse no flag", 1'b0, 16'h0);

    // R2: long pin pulse accepted; reset appears on the edge after the 4th sample
    pinReq = 1'b1;
    for (int i = 0; i < 4; i++) tick("R2 pin filtering", 1'b0, 16'h0);
    expFlags = 16'h0080;
    tick("R2 R5 pin accepted bit7", 1'b1, expFlags);
    pinReq = 1'b0;
    relax("R2 R3 pin release", 17);

    // R9: write clearing and cause on the same edge
    regWrEn = 1'b1; regWrData = 16'h0000; wdtReq = 1'b1;
    expFlags = 16'h0010;
    tick("R9 cause beats write", 1'b1, expFlags);
    regWrEn = 1'b0; wdtReq = 1'b0;
    relax("R3 R10 release after collision", 16);

    // R4: power-on in the middle of a run
    swWrite(16'hFFFF, "R7 set all before power-on");
    #1 porReq = 1'b1;
    #1;
    testsRun++;
    if (regRdData !== 16'h0003 || sysRst !== 1'b1) begin
      testsFailed++;
      $display("FAIL R3 R4 immediate power-on: flags=%h sysRst=%0b expected flags=0003 sysRst=1",
               regRdData, sysRst);
    end
    @(negedge clk);
    expFlags = 16'h0003;
    tick("R4 mid-run power-on", 1'b1, expFlags);
    porReq = 1'b0;
    relax("R3 R4 release after mid-run power-on", 16);

    @(negedge clk);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule